// File: doc/BRIEF.md
# Streaming Fixed-Point Multiply-Accumulate Engine

This block multiplies two 16-bit operands on every clock where the input is marked valid and folds the product into a 40-bit accumulator. Configuration inputs pick the number format (plain integer or Q15 fraction) and whether the operands are treated as signed or unsigned. Per-sample control bits negate the product, choose between adding to the accumulator and loading it, and request rounding of the 16-bit result taken from the accumulator.

A built-in run counter sizes inner loops. It takes a configured length at the first sample of a run and counts samples down. The last sample of a run raises the output valid flag two cycles later, and the sample after it starts a fresh sum on its own. A new operand pair may arrive on every cycle, so a run of N samples finishes N+1 cycles after its first sample. The full accumulator is always visible. A 16-bit result is also derived from it.

Top module: `mac_engine`

## Requirements
- R1: In signed integer mode the product of two 16-bit two's-complement operands is sign-extended to 40 bits, so a loaded product of -3 and 1000 reads as 40'hFFFFFFF448.
- R2: With `cfg_signed` low both operands are zero-extended, so 16'hFFFF times 16'hFFFF loads 40'h00FFFE0001.
- R3: With `cfg_q15` high the product is doubled before it is accumulated; -1.0 times -1.0 (16'h8000 squared, signed) gives 40'h0080000000 and a result of 16'h8000, wrapping without any flag.
- R4: An operand pair presented before clock edge k shows in `out_acc` after edge k+2, and pairs may be presented on consecutive cycles.
- R5: A valid sample with `in_acc` high adds its product to the accumulator; with `in_acc` low it replaces the accumulator with its product.
- R6: A valid sample with `in_neg` high contributes the negated product.
- R7: `out_res` is bits [31:16] of the accumulator plus 2^15 when the last valid sample had `in_rnd` high, and bits [31:16] of the plain accumulator otherwise.
- R8: The run counter takes `cfg_loop_len` at the first sample of a run; the sample that ends the run (the Nth, or every sample when the length is 0 or 1) raises `out_valid` for exactly one cycle, two edges after that sample.
- R9: The first sample after a run ends loads the accumulator even when its `in_acc` is high.
- R10: The accumulator holds 40 bits, keeping sums beyond 32 bits, and wraps modulo 2^40 on overflow.
- R11: Cycles with `in_valid` low leave the accumulator and the run position unchanged.
- R12: After reset the accumulator is zero, `out_valid` is low and the next sample starts a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_q15 | input | 1 | 1 selects Q15 fraction format, 0 integer |
| cfg_signed | input | 1 | 1 treats operands as two's complement |
| cfg_loop_len | input | 8 | Samples per run (0 and 1 end every sample) |
| in_valid | input | 1 | Operand pair and controls are present |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_neg | input | 1 | Negate this product |
| in_acc | input | 1 | Add to accumulator (1) or load it (0) |
| in_rnd | input | 1 | Round the result taken after this sample |
| out_valid | output | 1 | Pulse marking the end of a run |
| out_acc | output | 40 | Accumulator contents |
| out_res | output | 16 | Upper result word, optionally rounded |

## Verification
The bench targets the Q15 square of -1.0, where a design that forgot the doubling or truncated the product to 32 bits would report a negative or halved value. It streams a run on consecutive cycles and samples the accumulator mid-run, which exposes a third pipeline stage or a dropped sample. A 129-sample unsigned Q15 run carries the sum past 2^40, so an accumulator narrower than 40 bits or one that saturates reads wrong. It also starts runs with `in_acc` high, inserts idle cycles inside a run, and uses a run length of zero, which catch a missed restart, a counter that moves on idle cycles and an off-by-one terminal flag.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate engine.
// Assumes nothing beyond being compiled before the modules that import it.
package mac_pkg;

    // Per-sample side information that travels alongside the product.
    typedef struct packed {
        logic vld;   // sample present
        logic load;  // replace accumulator rather than add
        logic rnd;   // round the result after this sample
        logic last;  // sample closes a run
    } mac_tag_t;

endpackage

// File: rtl/mac_loop_ctr.sv
// Run counter: tracks how many samples remain in the current inner loop.
// Assumes cfg_len is held stable while a run is in progress; a length of
// 0 or 1 makes every sample a run on its own.
module mac_loop_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] cfg_len,
    output logic             run_first,
    output logic             run_last
);

    logic [CNT_W-1:0] remain;   // 0 means no run open
    logic [CNT_W-1:0] cur;

    // Pick the count that applies to the sample now at the input.
    always_comb begin
        run_first = (remain == '0);
        cur       = run_first ? cfg_len : remain;
        run_last  = (cur <= CNT_W'(1));
    end

    // Step the counter only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (in_valid) begin
            remain <= run_last ? '0 : cur - CNT_W'(1);
        end
    end

    // R8
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run_first && cfg_len > CNT_W'(1)) |=> (remain == CNT_W'($past(cfg_len) - CNT_W'(1))));

    // R8
    end_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run_last) |=> run_first);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(remain));

endmodule

// File: rtl/mac_mult.sv
// First pipeline stage: extends operands per the sign setting, forms the
// full product, applies the Q15 doubling and optional negation, and
// registers the result together with the sample's tag.
// Assumes ACC_W is at least 2*OP_W+2 so no product bit is lost.
module mac_mult
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    is_signed,
    input  logic                    q15,
    input  logic                    neg,
    input  logic [OP_W-1:0]         op_a,
    input  logic [OP_W-1:0]         op_b,
    input  mac_tag_t                tag_in,
    output logic signed [ACC_W-1:0] prod_q,
    output mac_tag_t                tag_q
);

    localparam int EXT_W  = OP_W + 1;
    localparam int PROD_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  ext_a, ext_b;
    logic signed [PROD_W-1:0] prod_full;
    logic signed [ACC_W-1:0]  prod_wide, prod_fmt, prod_out;

    // Form the formatted, optionally negated product.
    always_comb begin
        ext_a     = {is_signed & op_a[OP_W-1], op_a};
        ext_b     = {is_signed & op_b[OP_W-1], op_b};
        prod_full = PROD_W'(ext_a) * PROD_W'(ext_b);
        prod_wide = ACC_W'(prod_full);
        prod_fmt  = q15 ? (prod_wide <<< 1) : prod_wide;
        prod_out  = neg ? -prod_fmt : prod_fmt;
    end

    // Capture the product and its tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            tag_q  <= '0;
        end else begin
            tag_q <= tag_in;
            if (tag_in.vld) prod_q <= prod_out;
        end
    end

    // R1
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_in.vld && (op_a == '0 || op_b == '0)) |=> (prod_q == '0));

endmodule

// File: rtl/mac_accum.sv
// Second pipeline stage: loads or adds the product into the accumulator,
// issues the end-of-run pulse and derives the 16-bit result word.
// Assumes the product arrives already formatted and sign-extended.
module mac_accum
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] prod_q,
    input  mac_tag_t                tag_q,
    output logic signed [ACC_W-1:0] acc,
    output logic                    done,
    output logic [OP_W-1:0]         res
);

    localparam logic [ACC_W-1:0] RND_K = ACC_W'(1) << (OP_W - 1);

    logic             rnd_q;
    logic [ACC_W-1:0] res_sum;

    // Update the accumulator and output flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            done  <= 1'b0;
            rnd_q <= 1'b0;
        end else begin
            done <= tag_q.vld & tag_q.last;
            if (tag_q.vld) begin
                acc   <= tag_q.load ? prod_q : acc + prod_q;
                rnd_q <= tag_q.rnd;
            end
        end
    end

    // Take the result word, adding half an LSB when rounding.
    always_comb begin
        res_sum = acc + (rnd_q ? RND_K : '0);
        res     = res_sum[2*OP_W-1:OP_W];
    end

    // R5
    load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_q.vld && tag_q.load) |=> (acc == $past(prod_q)));

    // R11
    idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_q.vld |=> $stable(acc));

    // R8
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tag_q.vld && tag_q.last));

endmodule

// File: rtl/mac_engine.sv
// Top of the multiply-accumulate engine: run counter, product stage and
// accumulator stage in a two-register pipeline.
// Assumes configuration inputs change only between runs.
module mac_engine
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_q15,
    input  logic             cfg_signed,
    input  logic [CNT_W-1:0] cfg_loop_len,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    input  logic             in_neg,
    input  logic             in_acc,
    input  logic             in_rnd,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_acc,
    output logic [OP_W-1:0]  out_res
);

    logic                    run_first, run_last;
    mac_tag_t                tag_in, tag_q;
    logic signed [ACC_W-1:0] prod_q;
    logic signed [ACC_W-1:0] acc_q;

    mac_loop_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cfg_len   (cfg_loop_len),
        .run_first (run_first),
        .run_last  (run_last)
    );

    // Bundle per-sample control; a new run always loads.
    always_comb begin
        tag_in.vld  = in_valid;
        tag_in.load = ~in_acc | run_first;
        tag_in.rnd  = in_rnd;
        tag_in.last = run_last;
    end

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_signed (cfg_signed),
        .q15       (cfg_q15),
        .neg       (in_neg),
        .op_a      (in_a),
        .op_b      (in_b),
        .tag_in    (tag_in),
        .prod_q    (prod_q),
        .tag_q     (tag_q)
    );

    mac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .prod_q (prod_q),
        .tag_q  (tag_q),
        .acc    (acc_q),
        .done   (out_valid),
        .res    (out_res)
    );

    assign out_acc = acc_q;

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run_last) |=> ##1 out_valid);

endmodule

// File: tb/mac_engine_tb.sv
module mac_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_q15, cfg_signed;
    logic [7:0]  cfg_loop_len;
    logic        in_valid, in_neg, in_acc, in_rnd;
    logic [15:0] in_a, in_b;
    logic        out_valid;
    logic [39:0] out_acc;
    logic [15:0] out_res;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    mac_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_q15(cfg_q15), .cfg_signed(cfg_signed),
        .cfg_loop_len(cfg_loop_len), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_neg(in_neg), .in_acc(in_acc), .in_rnd(in_rnd),
        .out_valid(out_valid), .out_acc(out_acc), .out_res(out_res)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic [15:0] b,
                        input logic ng, input logic ac, input logic rd);
        in_valid = 1'b1; in_a = a; in_b = b; in_neg = ng; in_acc = ac; in_rnd = rd;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0; in_neg = 1'b0; in_acc = 1'b0; in_rnd = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input logic q, input logic s, input logic [7:0] len);
        cfg_q15 = q; cfg_signed = s; cfg_loop_len = len;
    endtask

    task automatic t_reset();
        chk("R12 acc", out_acc, 40'h0);
        chk("R12 valid", {39'h0, out_valid}, 40'h0);
    endtask

    task automatic t_signed_int();
        setup(1'b0, 1'b1, 8'd1);
        push(16'hFFFD, 16'd1000, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R1 signed product", out_acc, 40'hFFFFFFF448);
        chk("R8 single run valid", {39'h0, out_valid}, 40'h1);
    endtask

    task automatic t_unsigned();
        setup(1'b0, 1'b0, 8'd1);
        push(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R2 unsigned product", out_acc, 40'h00FFFE0001);
    endtask

    task automatic t_q15();
        setup(1'b1, 1'b1, 8'd1);
        push(16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R3 q15 -1*-1 acc", out_acc, 40'h0080000000);
        chk("R3 q15 -1*-1 res", {24'h0, out_res}, 40'h8000);
        push(16'h4000, 16'h4000, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R3 q15 half squared", out_acc, 40'h0020000000);
        chk("R3 q15 quarter res", {24'h0, out_res}, 40'h2000);
    endtask

    task automatic t_latency();
        setup(1'b0, 1'b1, 8'd3);
        push(16'd5, 16'd6, 1'b0, 1'b1, 1'b0);   // R9: acc high but run start loads
        push(16'd7, 16'd8, 1'b0, 1'b1, 1'b0);
        chk("R4 R9 first sample after two edges", out_acc, 40'd30);
        chk("R8 no early valid", {39'h0, out_valid}, 40'h0);
        push(16'hFFFE, 16'd10, 1'b0, 1'b1, 1'b0);
        chk("R4 R5 second sample", out_acc, 40'd86);
        idle();
        chk("R5 third sample", out_acc, 40'd66);
        chk("R8 run end valid", {39'h0, out_valid}, 40'h1);
        idle();
        chk("R8 valid one cycle", {39'h0, out_valid}, 40'h0);
    endtask

    task automatic t_negate();
        setup(1'b0, 1'b1, 8'd2);
        push(16'd100, 16'd7, 1'b0, 1'b1, 1'b0);
        push(16'd5, 16'd5, 1'b1, 1'b1, 1'b0);
        idle();
        chk("R6 negated product", out_acc, 40'd675);
    endtask

    task automatic t_load_mid();
        setup(1'b0, 1'b1, 8'd3);
        push(16'd10, 16'd10, 1'b0, 1'b1, 1'b0);
        push(16'd2, 16'd2, 1'b0, 1'b0, 1'b0);
        push(16'd3, 16'd3, 1'b0, 1'b1, 1'b0);
        idle();
        chk("R5 mid-run load then add", out_acc, 40'd13);
    endtask

    task automatic t_round();
        setup(1'b0, 1'b0, 8'd1);
        push(16'd3, 16'h8000, 1'b0, 1'b0, 1'b1);
        idle();
        chk("R7 rounded res", {24'h0, out_res}, 40'h2);
        push(16'd3, 16'h8000, 1'b0, 1'b0, 1'b0);
        idle();
        chk("R7 truncated res", {24'h0, out_res}, 40'h1);
    endtask

    task automatic t_guard();
        setup(1'b0, 1'b1, 8'd4);
        for (int i = 0; i < 4; i++) push(16'h7FFF, 16'h7FFF, 1'b0, 1'b1, 1'b0);
        idle();
        chk("R10 guard bits keep sum", out_acc, 40'h00FFFC0004);
    endtask

    task automatic t_wrap();
        logic [63:0] sum;
        sum = 64'h0;
        setup(1'b1, 1'b0, 8'd129);
        for (int i = 0; i < 129; i++) begin
            push(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0);
            sum = sum + (64'hFFFE0001 << 1);
        end
        idle();
        chk("R10 wrap modulo 2^40", out_acc, sum[39:0]);
        chk("R8 long run valid", {39'h0, out_valid}, 40'h1);
    endtask

    task automatic t_idle();
        setup(1'b0, 1'b1, 8'd2);
        push(16'd4, 16'd4, 1'b0, 1'b1, 1'b0);
        idle();
        chk("R11 first of run", out_acc, 40'd16);
        idle();
        idle();
        chk("R11 held over idles", out_acc, 40'd16);
        chk("R11 run still open", {39'h0, out_valid}, 40'h0);
        push(16'd1, 16'd1, 1'b0, 1'b1, 1'b0);
        idle();
        chk("R11 resume add", out_acc, 40'd17);
        chk("R11 run ends after idles", {39'h0, out_valid}, 40'h1);
    endtask

    task automatic t_len0();
        setup(1'b0, 1'b1, 8'd0);
        push(16'd2, 16'd3, 1'b0, 1'b1, 1'b0);
        push(16'd4, 16'd5, 1'b0, 1'b1, 1'b0);
        chk("R8 len0 first valid", {39'h0, out_valid}, 40'h1);
        chk("R8 len0 first acc", out_acc, 40'd6);
        idle();
        chk("R8 R9 len0 second restarts", out_acc, 40'd20);
        chk("R8 len0 second valid", {39'h0, out_valid}, 40'h1);
    endtask

    initial begin
        rst_n = 1'b0;
        setup(1'b0, 1'b1, 8'd1);
        in_valid = 1'b0; in_a = '0; in_b = '0; in_neg = 1'b0; in_acc = 1'b0; in_rnd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_int();
        t_unsigned();
        t_q15();
        t_latency();
        t_negate();
        t_load_mid();
        t_round();
        t_guard();
        t_wrap();
        t_idle();
        t_len0();
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule